// File: doc/BRIEF.md
# Peripheral Register Space Bridge

This block sits between a small processor core and the control and status registers of its peripherals. Every request carries an operation code, an address, a bit number and write data. Two kinds of request reach one shared register file. Short-address port operations use a 6-bit port number. Full data-space loads and stores use an 8-bit address, and the same low registers appear there shifted up by 0x20. Above that low window sits an extended register window that only data-space loads and stores can reach.

Single-bit set, clear and test operations work on the lower half of the port window. Status registers hold flags that peripheral events raise and that software clears by writing a one. A bit operation on such a register touches only the addressed flag. Peripheral events are modelled as one set-strobe input per flag.

Requests are combinational. Read data, the test bit and the error strobe are valid in the same cycle as the request. Register updates land on the next rising clock edge.

Top module: `regspace_bridge`

## Requirements
- R1: Operation codes are: 0 idle, 1 port read, 2 port write, 3 data load, 4 data store, 5 bit set, 6 bit clear, 7 bit test. A port read or port write at port p (req_addr[5:0]) reaches the same register as a data load or data store at data address p+0x20.
- R2: Data addresses 0x60 up to 0x60+EXT_IMPL-1 form the extended window, which is reachable only by data load and data store. A port operation (codes 1, 2, 5, 6, 7) whose req_addr[7:6] is nonzero raises op_err, reads as 0 and changes no register.
- R3: Bit set and bit clear at ports 0x00 to 0x1F on an ordinary register change only bit req_bit of that register.
- R4: Bit test at ports 0x00 to 0x1F returns bit req_bit of the addressed register on tst_bit in the same cycle.
- R5: A bit operation (codes 5, 6, 7) at ports 0x20 to 0x3F raises op_err, changes no register and drives tst_bit to 0.
- R6: The status registers at ports STAT_PORT to STAT_PORT+NUM_STAT-1 hold write-one-to-clear flags. A port write or data store clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged.
- R7: A bit set on a status register clears only the addressed flag. A bit clear on a status register changes nothing.
- R8: hw_flag_set[8k+b] sets flag b of status register k on the next edge. When it coincides with a write-one-to-clear of that flag, the flag ends up set.
- R9: Data addresses below 0x20 and from 0x60+EXT_IMPL upward are reserved: writes to them are ignored and reads return 0. The register at port RSV_PORT implements only the bits in RSV_BITS. Its other bits ignore writes and read as 0.
- R10: Reads (rd_data, tst_bit, op_err) are combinational in the request cycle. Writes take effect at the next rising edge. All registers are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_op | input | 3 | Operation code (see R1) |
| req_addr | input | 8 | Port number in [5:0] for port operations, or full data address |
| req_bit | input | 3 | Bit number for bit set, clear and test |
| req_wdata | input | 8 | Write data for port write and data store |
| hw_flag_set | input | 8*NUM_STAT | Peripheral event strobes, one per status flag |
| rd_data | output | 8 | Read data for port read and data load; 0 otherwise |
| tst_bit | output | 1 | Result of a bit test |
| op_err | output | 1 | Illegal address for the requested operation |

## Verification
The bound checker watches several rules on every cycle:
- A bit operation in the upper port half always raises the error strobe.
- An error never lets a write through.
- A status flag only rises after a peripheral event and only falls after a write aimed at a status register.
- A single bit operation clears at most one flag.
- A peripheral event always leaves its flag set, even when a clear lands on it in the same cycle.

Only the bench's sweeps can show the following:
- The two address views alias the same storage.
- Reserved addresses and bits read back as zero.
- An ordinary register keeps all its other bits through a bit set or bit clear.
- A write becomes visible one cycle later.

// File: rtl/regbr_pkg.sv
package regbr_pkg;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_PIN  = 3'd1,
    OP_POUT = 3'd2,
    OP_DLD  = 3'd3,
    OP_DST  = 3'd4,
    OP_BSET = 3'd5,
    OP_BCLR = 3'd6,
    OP_BTST = 3'd7
  } req_op_e;

  localparam logic [7:0] PORT_OFFSET = 8'h20;
  localparam logic [7:0] EXT_BASE    = 8'h60;

  // Map a 6-bit port number to its data-space address.
  function automatic logic [7:0] port_to_data(input logic [5:0] p);
    return {2'b00, p} + PORT_OFFSET;
  endfunction

  function automatic logic [7:0] one_hot_bit(input logic [2:0] b);
    return 8'h01 << b;
  endfunction

  // Bits that exist at a data address; 0 means the address is reserved.
  function automatic logic [7:0] impl_mask(input logic [7:0] da,
                                           input int unsigned ext_impl,
                                           input logic [5:0] rsv_port,
                                           input logic [7:0] rsv_bits);
    if (da < PORT_OFFSET) return 8'h00;
    if (32'(da) >= 32'(EXT_BASE) + ext_impl) return 8'h00;
    if (da == port_to_data(rsv_port)) return rsv_bits;
    return 8'hFF;
  endfunction

  // Byte written for a bit set/clear. For write-one-to-clear targets,
  // only the addressed bit carries a one (set) or nothing does (clear).
  function automatic logic [7:0] merge_bitop(input logic [7:0] cur,
                                             input logic [2:0] b,
                                             input logic       set_not_clr,
                                             input logic       is_w1c);
    if (is_w1c) return set_not_clr ? one_hot_bit(b) : 8'h00;
    return set_not_clr ? (cur | one_hot_bit(b)) : (cur & ~one_hot_bit(b));
  endfunction

endpackage

// File: rtl/regbr_decode.sv
module regbr_decode
  import regbr_pkg::*;
#(
  parameter int unsigned EXT_IMPL = 32,
  parameter logic [5:0]  RSV_PORT = 6'h1E,
  parameter logic [7:0]  RSV_BITS = 8'h0F,
  parameter int unsigned IW       = 7
) (
  input  req_op_e         op,
  input  logic [7:0]      addr,
  output logic            rd_req,
  output logic            wr_req,
  output logic            bit_req,
  output logic            tst_req,
  output logic            hit,
  output logic [IW-1:0]   idx,
  output logic [7:0]      mask,
  output logic            err
);

  logic       is_port;
  logic       is_bit;
  logic [7:0] da;

  always_comb begin
    is_port = op inside {OP_PIN, OP_POUT, OP_BSET, OP_BCLR, OP_BTST};
    is_bit  = op inside {OP_BSET, OP_BCLR, OP_BTST};
    da      = is_port ? port_to_data(addr[5:0]) : addr;
    err     = (is_port && (addr[7:6] != 2'b00)) || (is_bit && addr[5]);
    mask    = impl_mask(da, EXT_IMPL, RSV_PORT, RSV_BITS);
    hit     = !err && (op != OP_IDLE) && (mask != 8'h00);
    idx     = IW'(da - PORT_OFFSET);
    rd_req  = hit && (op inside {OP_PIN, OP_DLD});
    wr_req  = hit && (op inside {OP_POUT, OP_DST});
    bit_req = hit && (op inside {OP_BSET, OP_BCLR});
    tst_req = hit && (op == OP_BTST);
  end

endmodule

// File: rtl/regbr_store.sv
module regbr_store
  import regbr_pkg::*;
#(
  parameter int unsigned NREG      = 96,
  parameter int unsigned IW        = 7,
  parameter int unsigned EXT_IMPL  = 32,
  parameter logic [5:0]  RSV_PORT  = 6'h1E,
  parameter logic [7:0]  RSV_BITS  = 8'h0F,
  parameter logic [5:0]  STAT_PORT = 6'h14,
  parameter int unsigned NUM_STAT  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_fire,
  input  logic [IW-1:0]         wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [NUM_STAT*8-1:0] hw_set,
  input  logic [IW-1:0]         rd_idx,
  output logic [7:0]            rd_val,
  output logic [NUM_STAT*8-1:0] stat_q
);

  logic [NREG-1:0][7:0] view;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [7:0] MSK = impl_mask(8'(i + 32), EXT_IMPL, RSV_PORT, RSV_BITS);
    localparam bit IS_STAT = (i >= int'(STAT_PORT)) && (i < int'(STAT_PORT) + int'(NUM_STAT));
    logic [7:0] q;
    logic       sel;
    assign sel     = wr_fire && (wr_idx == IW'(i));
    assign view[i] = q;

    if (IS_STAT) begin : g_w1c
      localparam int K = i - int'(STAT_PORT);
      logic [7:0] clr;
      assign clr = sel ? wr_data : 8'h00;
      // hardware set is ORed after the clear, so it wins
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 8'h00;
        else        q <= ((q & ~clr) | hw_set[K*8 +: 8]) & MSK;
      end
      assign stat_q[K*8 +: 8] = q;
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= 8'h00;
        else if (sel) q <= wr_data & MSK;
      end
    end
  end

  assign rd_val = (int'(rd_idx) < int'(NREG)) ? view[rd_idx] : 8'h00;

endmodule

// File: rtl/regspace_bridge.sv
module regspace_bridge
  import regbr_pkg::*;
#(
  parameter int unsigned EXT_IMPL  = 32,
  parameter logic [5:0]  STAT_PORT = 6'h14,
  parameter int unsigned NUM_STAT  = 2,
  parameter logic [5:0]  RSV_PORT  = 6'h1E,
  parameter logic [7:0]  RSV_BITS  = 8'h0F
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            req_op,
  input  logic [7:0]            req_addr,
  input  logic [2:0]            req_bit,
  input  logic [7:0]            req_wdata,
  input  logic [NUM_STAT*8-1:0] hw_flag_set,
  output logic [7:0]            rd_data,
  output logic                  tst_bit,
  output logic                  op_err
);

  localparam int unsigned NREG  = 64 + EXT_IMPL;
  localparam int unsigned IW    = $clog2(NREG);
  localparam int unsigned NFLAG = NUM_STAT * 8;

  req_op_e        op;
  logic           rd_req, wr_req, bit_req, tst_req, hit, dec_err;
  logic [IW-1:0]  idx;
  logic [7:0]     mask;
  logic [7:0]     cur;
  logic [NFLAG-1:0] stat_q;

  // named internal events for the checker
  logic           tgt_stat;
  logic           wr_fire;
  logic           bitop_fire;
  logic           stat_wr;
  logic [7:0]     wr_data;

  assign op = req_op_e'(req_op);

  regbr_decode #(
    .EXT_IMPL(EXT_IMPL), .RSV_PORT(RSV_PORT), .RSV_BITS(RSV_BITS), .IW(IW)
  ) u_decode (
    .op(op), .addr(req_addr),
    .rd_req(rd_req), .wr_req(wr_req), .bit_req(bit_req), .tst_req(tst_req),
    .hit(hit), .idx(idx), .mask(mask), .err(dec_err)
  );

  assign tgt_stat   = hit && (int'(idx) >= int'(STAT_PORT))
                          && (int'(idx) < int'(STAT_PORT) + int'(NUM_STAT));
  assign bitop_fire = bit_req;
  assign wr_fire    = wr_req || bit_req;
  assign stat_wr    = wr_fire && tgt_stat;
  assign wr_data    = bit_req ? merge_bitop(cur, req_bit, op == OP_BSET, tgt_stat)
                              : req_wdata;

  regbr_store #(
    .NREG(NREG), .IW(IW), .EXT_IMPL(EXT_IMPL), .RSV_PORT(RSV_PORT),
    .RSV_BITS(RSV_BITS), .STAT_PORT(STAT_PORT), .NUM_STAT(NUM_STAT)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_fire), .wr_idx(idx), .wr_data(wr_data),
    .hw_set(hw_flag_set), .rd_idx(idx), .rd_val(cur), .stat_q(stat_q)
  );

  assign rd_data = rd_req ? (cur & mask) : 8'h00;
  assign tst_bit = tst_req ? cur[req_bit] : 1'b0;
  assign op_err  = dec_err;

endmodule

// File: rtl/regbr_chk.sv
module regbr_chk #(
  parameter int unsigned NFLAG = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       req_op,
  input logic             addr_b5,
  input logic             op_err,
  input logic             tst_bit,
  input logic             wr_fire,
  input logic             bitop_fire,
  input logic             stat_wr,
  input logic [NFLAG-1:0] hw_flag_set,
  input logic [NFLAG-1:0] stat_q
);

  // R5
  upper_bitop_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_op >= 3'd5) && addr_b5) |-> op_err);

  // R2
  err_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> !wr_fire);

  // R5
  err_tst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> !tst_bit);

  // R8
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_flag_set != '0) |=> ((stat_q & $past(hw_flag_set)) == $past(hw_flag_set)));

  // R8
  flag_rise_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & ~$past(hw_flag_set)) == '0));

  // R6
  flag_fall_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> (($past(stat_q) & ~stat_q) == '0));

  // R7
  bitop_single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitop_fire |=> ($countones($past(stat_q) & ~stat_q) <= 1));

endmodule

bind regspace_bridge regbr_chk #(.NFLAG(NFLAG)) u_regbr_chk (
  .clk(clk), .rst_n(rst_n), .req_op(req_op), .addr_b5(req_addr[5]),
  .op_err(op_err), .tst_bit(tst_bit), .wr_fire(wr_fire),
  .bitop_fire(bitop_fire), .stat_wr(stat_wr),
  .hw_flag_set(hw_flag_set), .stat_q(stat_q)
);

// File: tb/test_regspace_bridge.sv
module test_regspace_bridge;

  localparam logic [2:0] C_IDLE = 3'd0, C_PIN = 3'd1, C_POUT = 3'd2, C_DLD = 3'd3,
                         C_DST = 3'd4, C_BSET = 3'd5, C_BCLR = 3'd6, C_BTST = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [7:0]  req_addr = 8'h00;
  logic [2:0]  req_bit = 3'd0;
  logic [7:0]  req_wdata = 8'h00;
  logic [15:0] hw_flag_set = 16'h0;
  logic [7:0]  rd_data;
  logic        tst_bit;
  logic        op_err;

  regspace_bridge i_regspace_bridge (
    .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_addr(req_addr),
    .req_bit(req_bit), .req_wdata(req_wdata), .hw_flag_set(hw_flag_set),
    .rd_data(rd_data), .tst_bit(tst_bit), .op_err(op_err)
  );

  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0] m [256];
  logic [7:0] got_rd, exp_rd;
  logic       got_tst, exp_tst, got_err, exp_err;

  // small-configuration rules: extended window ends at 0x80,
  // status flags at data 0x34/0x35, partial register at data 0x3E
  function automatic logic [7:0] bmask(input int da);
    if (da < 32 || da >= 128) return 8'h00;
    if (da == 8'h3E) return 8'h0F;
    return 8'hFF;
  endfunction

  function automatic bit isstat(input int da);
    return (da == 8'h34) || (da == 8'h35);
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] addr,
                       input logic [2:0] b, input logic [7:0] wd, input logic [15:0] hw);
    bit   is_port, is_bit, legal;
    int   da;
    logic [7:0] nv, bm;
    @(negedge clk);
    req_op = op; req_addr = addr; req_bit = b; req_wdata = wd; hw_flag_set = hw;
    #1;
    got_rd = rd_data; got_tst = tst_bit; got_err = op_err;
    is_port = (op == C_PIN) || (op == C_POUT) || (op >= C_BSET);
    is_bit  = (op >= C_BSET);
    legal   = !(is_port && addr[7:6] != 2'b00) && !(is_bit && addr[5]);
    da      = is_port ? 32 + int'(addr[5:0]) : int'(addr);
    bm      = 8'h01 << b;
    exp_err = is_port && !legal;
    exp_rd  = (legal && (op == C_PIN || op == C_DLD)) ? m[da] : 8'h00;
    exp_tst = (legal && op == C_BTST) ? m[da][b] : 1'b0;
    if (legal && bmask(da) != 8'h00) begin
      nv = m[da];
      if (op == C_POUT || op == C_DST) nv = isstat(da) ? (m[da] & ~wd) : wd;
      if (op == C_BSET) nv = isstat(da) ? (m[da] & ~bm) : (m[da] | bm);
      if (op == C_BCLR) nv = isstat(da) ? m[da] : (m[da] & ~bm);
      m[da] = nv & bmask(da);
    end
    m[8'h34] = m[8'h34] | hw[7:0];
    m[8'h35] = m[8'h35] | hw[15:8];
  endtask

  task automatic idle();
    issue(C_IDLE, 8'h00, 3'd0, 8'h00, 16'h0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) m[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R10 reset state via data loads over the whole space
    for (int a = 0; a < 256; a++) begin
      issue(C_DLD, 8'(a), 3'd0, 8'h00, 16'h0);
      chk("R10 reset read", got_rd, 0);
    end

    // R9/R10 store sweep then read back next cycle
    for (int a = 0; a < 256; a++) issue(C_DST, 8'(a), 3'd0, 8'((a * 37 + 11) & 255), 16'h0);
    for (int a = 0; a < 256; a++) begin
      issue(C_DLD, 8'(a), 3'd0, 8'h00, 16'h0);
      chk((a < 32 || a >= 128) ? "R9 reserved read" : "R10 store readback", got_rd, exp_rd);
    end

    // R1 port view aliases data view
    for (int p = 0; p < 64; p++) begin
      issue(C_PIN, 8'(p), 3'd0, 8'h00, 16'h0);
      chk("R1 port read", got_rd, exp_rd);
      issue(C_POUT, 8'(p), 3'd0, 8'((p * 5 + 3) ^ 8'hA5), 16'h0);
      issue(C_DLD, 8'(p + 32), 3'd0, 8'h00, 16'h0);
      chk(p == 8'h1E ? "R9 partial reg" : "R1 alias load", got_rd, exp_rd);
    end

    // R2 port ops with high address bits rejected; extended window untouched
    for (int h = 1; h < 4; h++) begin
      issue(C_PIN, 8'(h * 64 + 8), 3'd0, 8'h00, 16'h0);
      chk("R2 port err", got_err, 1);
      chk("R2 port read zero", got_rd, 0);
      issue(C_POUT, 8'(h * 64 + 8), 3'd0, 8'h5A, 16'h0);
      chk("R2 port write err", got_err, 1);
      issue(C_DLD, 8'h28, 3'd0, 8'h00, 16'h0);
      chk("R2 low reg unchanged", got_rd, exp_rd);
      issue(C_DLD, 8'(h * 64 + 8), 3'd0, 8'h00, 16'h0);
      chk("R2 data view unchanged", got_rd, exp_rd);
    end

    // R3/R4 bit set, clear and test over every bit of the low half
    for (int p = 0; p < 32; p++) begin
      if (p == 8'h14 || p == 8'h15) continue;
      for (int b = 0; b < 8; b++) begin
        issue(C_BSET, 8'(p), 3'(b), 8'h00, 16'h0);
        issue(C_BTST, 8'(p), 3'(b), 8'h00, 16'h0);
        chk("R4 test after set", got_tst, exp_tst);
        issue(C_DLD, 8'(p + 32), 3'd0, 8'h00, 16'h0);
        chk("R3 set only bit", got_rd, exp_rd);
        issue(C_BCLR, 8'(p), 3'(b), 8'h00, 16'h0);
        issue(C_BTST, 8'(p), 3'(b), 8'h00, 16'h0);
        chk("R4 test after clear", got_tst, 0);
        issue(C_DLD, 8'(p + 32), 3'd0, 8'h00, 16'h0);
        chk("R3 clear only bit", got_rd, exp_rd);
      end
    end

    // R5 bit ops in upper port half rejected
    for (int p = 32; p < 64; p++) begin
      issue(C_BSET, 8'(p), 3'(p % 8), 8'h00, 16'h0);
      chk("R5 set err", got_err, 1);
      issue(C_BTST, 8'(p), 3'(p % 8), 8'h00, 16'h0);
      chk("R5 test err", got_err, 1);
      chk("R5 test zero", got_tst, 0);
      issue(C_BCLR, 8'(p), 3'(p % 8), 8'h00, 16'h0);
      issue(C_DLD, 8'(p + 32), 3'd0, 8'h00, 16'h0);
      chk("R5 reg unchanged", got_rd, exp_rd);
    end

    // R6/R7/R8 status flags
    issue(C_IDLE, 8'h00, 3'd0, 8'h00, 16'hFFFF);
    issue(C_DLD, 8'h34, 3'd0, 8'h00, 16'h0);
    chk("R8 hw set", got_rd, 8'hFF);
    issue(C_BSET, 8'h14, 3'd2, 8'h00, 16'h0);
    issue(C_DLD, 8'h34, 3'd0, 8'h00, 16'h0);
    chk("R7 set clears one flag", got_rd, 8'hFB);
    issue(C_BCLR, 8'h14, 3'd5, 8'h00, 16'h0);
    issue(C_PIN, 8'h14, 3'd0, 8'h00, 16'h0);
    chk("R7 clear no effect", got_rd, 8'hFB);
    issue(C_POUT, 8'h14, 3'd0, 8'h00, 16'h0);
    issue(C_PIN, 8'h14, 3'd0, 8'h00, 16'h0);
    chk("R6 write zero keeps", got_rd, 8'hFB);
    issue(C_POUT, 8'h14, 3'd0, 8'h81, 16'h0);
    issue(C_PIN, 8'h14, 3'd0, 8'h00, 16'h0);
    chk("R6 write one clears", got_rd, 8'h7A);
    issue(C_DST, 8'h35, 3'd0, 8'h0F, 16'h0);
    issue(C_DLD, 8'h35, 3'd0, 8'h00, 16'h0);
    chk("R6 data store clears", got_rd, 8'hF0);
    issue(C_POUT, 8'h14, 3'd0, 8'h02, 16'h0002);
    issue(C_PIN, 8'h14, 3'd0, 8'h00, 16'h0);
    chk("R8 set beats clear", got_rd, 8'h7A);
    issue(C_BSET, 8'h15, 3'd4, 8'h00, 16'h0100);
    issue(C_DLD, 8'h35, 3'd0, 8'h00, 16'h0);
    chk("R8 event plus R7 bit clear", got_rd, 8'hE1);
    issue(C_BTST, 8'h15, 3'd0, 8'h00, 16'h0);
    chk("R4 status test", got_tst, 1);
    issue(C_DLD, 8'h34, 3'd0, 8'h00, 16'h0);
    chk("R8 other reg untouched", got_rd, exp_rd);
    idle();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule